// File: doc/BRIEF.md
# Selectable PRBS Generator With Error Injection

This block feeds a serial link transmitter with a parallel word of pseudo-random test data on every clock. A three-bit code picks one of five maximal-length polynomials at run time. The shift register inside walks W serial steps per clock, and bit 0 of each word is the first bit sent on the wire. After a reset, or whenever the code changes, the register reloads an all-ones seed. This keeps it out of the all-zero state and gives a receiving checker a known place to start.

Two controls shape the word after it is generated. A polarity input inverts every bit of the word. A force-error input flips bit 0 of the following word under one of two policies. In the first policy each sampled high cycle causes one flip. In the second, only a low-to-high transition causes a flip. An injected error does not disturb the shift register, so a checker sees exactly one bit error and the sequence stays locked. Inversion is applied after the flip, so the flipped bit is still a single bit error in the inverted stream.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rst` is sampled high, `data_out` is 0 and `data_valid` is 0. At the first rising edge with `rst` low, `data_valid` becomes 1 and stays 1.
- R2: The serial sequence obeys b[k] = b[k-n] xor b[k-t]. The pattern codes are: `pat_sel`=0 gives n=7, t=6; 1 gives n=9, t=5; 2 gives n=15, t=14; 3 gives n=23, t=18; 4 gives n=31, t=28. Each word holds the next W bits, with the earliest bit in bit 0.
- R3: The word stream repeats after 2^n-1 words, because W·(2^n-1) bits is a whole number of periods. With W=32 this is 127 words for code 0 and 511 words for code 1.
- R4: After reset, the n bits that precede the first output bit are taken as all ones. The first word after reset is therefore fully determined by the code.
- R5: When the word produced at an edge uses a value of `pat_sel` different from the one used at the edge before, the sequence restarts from the all-ones history with the new polynomial.
- R6: Codes 5, 6 and 7 behave as code 4 (n=31, t=28).
- R7: When `invert` is sampled high at an edge, every bit of the word produced at that edge is inverted.
- R8: When `err_edge_mode`=0 (level policy), each edge that samples `force_err` high flips bit 0 of the word produced at the following edge.
- R9: When `err_edge_mode`=1 (edge policy), bit 0 of the following word is flipped only if `force_err` is sampled high and was sampled low at the edge before. A `force_err` held high through reset does not count as a transition.
- R10: An injected error leaves the sequence unchanged. The words that follow it carry the same bits they would have carried with no error.
- R11: When an error and inversion apply to the same word, the word differs from the inverted error-free word in bit 0 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 3 | Polynomial code (0..4; 5..7 act as 4) |
| invert | input | 1 | Invert every bit of the produced word |
| force_err | input | 1 | Error injection request |
| err_edge_mode | input | 1 | 0 = level policy, 1 = edge policy |
| data_out | output | W | Pattern word, bit 0 sent first |
| data_valid | output | 1 | High once the first word after reset is out |

## Verification
A wrong tap, a wrong seed or a missed reload on a code change breaks the recurrence inside the very first word after the event. The word-by-word comparison against the recurrence therefore shows it one edge later. A shift register that loses its place shows up either as a mismatch in the following word or as a broken repeat at the 127th or 511th word. A badly placed error flip shows up as a single wrong bit 0, either one word too early or too late, or repeated under the edge policy. A flip that leaks into the register state shows up as wrong bits in every word that follows.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

    localparam int MAX_ORDER = 31;

    typedef logic [MAX_ORDER-1:0] lfsr_t;

    typedef enum logic [2:0] {
        PAT_P7  = 3'd0,
        PAT_P9  = 3'd1,
        PAT_P15 = 3'd2,
        PAT_P23 = 3'd3,
        PAT_P31 = 3'd4
    } pat_e;

    typedef enum logic {
        ERR_LEVEL = 1'b0,
        ERR_EDGE  = 1'b1
    } err_mode_e;

    typedef struct packed {
        logic [4:0] order;
        logic [4:0] tap;
    } poly_t;

    typedef struct packed {
        logic  fb;
        lfsr_t nxt;
    } step_t;

    function automatic poly_t poly_of(input logic [2:0] code);
        poly_t p;
        case (code)
            PAT_P7:  p = '{order: 5'd7,  tap: 5'd6};
            PAT_P9:  p = '{order: 5'd9,  tap: 5'd5};
            PAT_P15: p = '{order: 5'd15, tap: 5'd14};
            PAT_P23: p = '{order: 5'd23, tap: 5'd18};
            default: p = '{order: 5'd31, tap: 5'd28};
        endcase
        return p;
    endfunction

    function automatic lfsr_t order_mask(input logic [4:0] order);
        logic [31:0] full;
        full = (32'd1 << order) - 32'd1;
        return full[MAX_ORDER-1:0];
    endfunction

    function automatic step_t lfsr_step(input lfsr_t s, input poly_t p);
        step_t r;
        r.fb  = s[p.order - 5'd1] ^ s[p.tap - 5'd1];
        r.nxt = {s[MAX_ORDER-2:0], r.fb} & order_mask(p.order);
        return r;
    endfunction

endpackage

// File: rtl/pg_lfsr_core.sv
module pg_lfsr_core
    import prbs_gen_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   pat_sel,
    output logic [W-1:0] raw_word
);

    lfsr_t       state_q;
    logic [2:0]  sel_q;
    poly_t       poly;
    lfsr_t       seed;
    lfsr_t       chain [W+1];
    step_t       steps [W];

    always_comb begin
        poly = poly_of(pat_sel);
        seed = order_mask(poly.order);
    end

    assign chain[0] = (pat_sel != sel_q) ? seed : state_q;

    generate
        for (genvar g = 0; g < W; g++) begin : g_step
            assign steps[g]     = lfsr_step(chain[g], poly);
            assign chain[g+1]   = steps[g].nxt;
            assign raw_word[g]  = steps[g].fb;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= seed;
            sel_q   <= pat_sel;
        end else begin
            state_q <= chain[W];
            sel_q   <= pat_sel;
        end
    end

    // R4
    nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R5
    reload_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_sel != sel_q) |-> (chain[0] == seed));

endmodule

// File: rtl/pg_err_inject.sv
module pg_err_inject
    import prbs_gen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic force_err,
    input  logic err_edge_mode,
    output logic err_pend
);

    err_mode_e mode;
    logic      force_q;
    logic      request;

    always_comb begin
        mode = err_mode_e'(err_edge_mode);
        case (mode)
            ERR_EDGE: request = force_err & ~force_q;
            default:  request = force_err;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q  <= 1'b1;
            err_pend <= 1'b0;
        end else begin
            force_q  <= force_err;
            err_pend <= request;
        end
    end

    // R8
    level_inject_chk: assert property (@(posedge clk) disable iff (rst)
        (!err_edge_mode && force_err) |=> err_pend);

    // R9
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_edge_mode && force_err && force_q) |=> !err_pend);

endmodule

// File: rtl/pg_out_stage.sv
module pg_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_word,
    input  logic         err_pend,
    input  logic         invert,
    output logic [W-1:0] data_out,
    output logic         data_valid
);

    logic [W-1:0] flip_mask;
    logic [W-1:0] pol_mask;

    assign flip_mask = W'(err_pend);
    assign pol_mask  = {W{invert}};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out   <= '0;
            data_valid <= 1'b0;
        end else begin
            data_out   <= (raw_word ^ flip_mask) ^ pol_mask;
            data_valid <= 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!data_valid && data_out == '0));

    // R11
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(data_out ^ $past(raw_word) ^ {W{$past(invert)}})
                  == ($past(err_pend) ? 1 : 0)));

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   pat_sel,
    input  logic         invert,
    input  logic         force_err,
    input  logic         err_edge_mode,
    output logic [W-1:0] data_out,
    output logic         data_valid
);

    logic [W-1:0] raw_word;
    logic         err_pend;

    pg_lfsr_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .pat_sel  (pat_sel),
        .raw_word (raw_word)
    );

    pg_err_inject u_err (
        .clk           (clk),
        .rst           (rst),
        .force_err     (force_err),
        .err_edge_mode (err_edge_mode),
        .err_pend      (err_pend)
    );

    pg_out_stage #(.W(W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .raw_word   (raw_word),
        .err_pend   (err_pend),
        .invert     (invert),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    // R1
    valid_stays_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> data_valid);

endmodule

// File: tb/prbs_pattern_gen_bench.sv
`timescale 1ns/1ps
module prbs_pattern_gen_bench;

    localparam int W = 32;

    typedef struct packed {
        logic [2:0] sel;
        logic       pol;
        logic       frc;
        logic       emode;
        logic [9:0] ncyc;
        logic [3:0] tag;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 10'd20, 4'd2},
        '{3'd1, 1'b0, 1'b0, 1'b0, 10'd20, 4'd5},
        '{3'd2, 1'b0, 1'b0, 1'b0, 10'd20, 4'd5},
        '{3'd3, 1'b0, 1'b0, 1'b0, 10'd20, 4'd5},
        '{3'd4, 1'b0, 1'b0, 1'b0, 10'd20, 4'd5},
        '{3'd7, 1'b0, 1'b0, 1'b0, 10'd10, 4'd6},
        '{3'd2, 1'b1, 1'b0, 1'b0, 10'd10, 4'd7},
        '{3'd2, 1'b0, 1'b1, 1'b0, 10'd3,  4'd8},
        '{3'd2, 1'b0, 1'b0, 1'b0, 10'd5,  4'd10},
        '{3'd2, 1'b0, 1'b1, 1'b1, 10'd4,  4'd9},
        '{3'd2, 1'b0, 1'b0, 1'b1, 10'd2,  4'd9},
        '{3'd2, 1'b0, 1'b1, 1'b1, 10'd2,  4'd9},
        '{3'd2, 1'b1, 1'b1, 1'b0, 10'd3,  4'd11},
        '{3'd2, 1'b1, 1'b0, 1'b0, 10'd4,  4'd10}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   pat_sel;
    logic         invert;
    logic         force_err;
    logic         err_edge_mode;
    logic [W-1:0] data_out;
    logic         data_valid;

    int errors = 0;
    int checks = 0;

    // model state
    logic [63:0]  m_hist;
    logic [2:0]   m_sel_q;
    logic         m_pend;
    logic         m_force_q;
    logic [W-1:0] m_word;
    logic         m_valid;

    always #2.5 clk = ~clk;

    prbs_pattern_gen #(.W(W)) u_prbs_pattern_gen (
        .clk           (clk),
        .rst           (rst),
        .pat_sel       (pat_sel),
        .invert        (invert),
        .force_err     (force_err),
        .err_edge_mode (err_edge_mode),
        .data_out      (data_out),
        .data_valid    (data_valid)
    );

    function automatic string tag_name(input logic [3:0] idx);
        case (idx)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int ord_of(input logic [2:0] c);
        case (c)
            3'd0: return 7;
            3'd1: return 9;
            3'd2: return 15;
            3'd3: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int tap_of(input logic [2:0] c);
        case (c)
            3'd0: return 6;
            3'd1: return 5;
            3'd2: return 14;
            3'd3: return 18;
            default: return 28;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp,
                         input logic actv, input logic expv);
        checks++;
        if (act !== exp || actv !== expv) begin
            errors++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     tag, act, actv, exp, expv);
        end
    endtask

    // one clock edge: model follows the requirements, then the outputs are compared
    task automatic step(input string tag);
        int n;
        int t;
        logic b;
        @(posedge clk);
        if (rst) begin
            m_hist    = '1;
            m_sel_q   = pat_sel;
            m_pend    = 1'b0;
            m_force_q = 1'b1;
            m_word    = '0;
            m_valid   = 1'b0;
        end else begin
            if (pat_sel != m_sel_q) m_hist = '1;
            m_sel_q = pat_sel;
            n = ord_of(pat_sel);
            t = tap_of(pat_sel);
            for (int i = 0; i < W; i++) begin
                b = m_hist[n-1] ^ m_hist[t-1];
                m_hist = {m_hist[62:0], b};
                m_word[i] = b;
            end
            if (m_pend) m_word[0] = ~m_word[0];
            if (invert) m_word = ~m_word;
            m_pend    = err_edge_mode ? (force_err & ~m_force_q) : force_err;
            m_force_q = force_err;
            m_valid   = 1'b1;
        end
        #2;
        check(tag, data_out, m_word, data_valid, m_valid);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [W-1:0] first;
        rst = 1'b1; pat_sel = 3'd0; invert = 1'b0; force_err = 1'b0; err_edge_mode = 1'b0;
        repeat (3) step("R1");
        rst = 1'b0;
        step("R4");   // first word after reset from all-ones history

        // table of vectors
        for (int r = 0; r < NROWS; r++) begin
            pat_sel = ROWS[r].sel; invert = ROWS[r].pol;
            force_err = ROWS[r].frc; err_edge_mode = ROWS[r].emode;
            for (int c = 0; c < int'(ROWS[r].ncyc); c++) step(tag_name(ROWS[r].tag));
        end

        // R1: reset in mid-run clears outputs; R9: force held through reset is no edge
        pat_sel = 3'd2; invert = 1'b0; force_err = 1'b1; err_edge_mode = 1'b1;
        rst = 1'b1;
        step("R1");
        step("R1");
        rst = 1'b0;
        step("R9");
        step("R9");
        step("R9");
        force_err = 1'b0;
        step("R9");

        // R3: repeat after 127 words for code 0
        rst = 1'b1; pat_sel = 3'd0; err_edge_mode = 1'b0;
        step("R1");
        rst = 1'b0;
        step("R3");
        first = data_out;
        for (int k = 1; k < 127; k++) step("R3");
        step("R3");
        check("R3", data_out, first, data_valid, 1'b1);

        // R3: repeat after 511 words for code 1 (select change restarts)
        pat_sel = 3'd1;
        step("R5");
        first = data_out;
        for (int k = 1; k < 511; k++) step("R3");
        step("R3");
        check("R3", data_out, first, data_valid, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule